// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a read or write burst inside an already opened row. A start strobe captures an 8-bit starting column together with three mode fields: a length code, an ordering bit and a write-burst override. From the next clock onward the block emits one column per enabled cycle. It raises a flag on the final beat of a fixed-length burst.

Two orderings are supported for fixed bursts. In sequential order the low bits count up and wrap inside an aligned block. In interleaved order the low bits are the starting bits XORed with the beat number. A full-page read walks the whole row and wraps until it is stopped. Write bursts follow their own rule: a full-page setting is capped to a fixed block, or every write can be forced to a single column.

A terminate strobe cuts the running burst short. A new start replaces the running burst. A clock-enable input freezes all progress. Reserved length codes fall back to a single column and raise an error flag.

Top module: `burst_colgen`

## Requirements
- R1: Length code 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 columns. With the ordering bit at 0 (sequential), the low log2(length) bits count up from the start modulo the length, and the upper column bits stay equal to the start's upper bits.
- R2: With the ordering bit at 1 (interleaved) and length 2, 4 or 8, the low log2(length) bits of beat k equal the start's low bits XOR k, and the upper bits stay fixed. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R3: Length code 3'b111 with the ordering bit at 0 on a read is a full-page burst. It starts at any column, adds 1 per beat, wraps from 255 to 0, never raises the last-beat flag, and runs until it is terminated or replaced.
- R4: For length code 3'b000 the ordering bit has no effect: one column, equal to the start, with the last-beat flag set.
- R5: When the write-single bit is 1, every write burst covers one column. Reads still use the programmed length and order.
- R6: When the write-single bit is 0, a write with length code 3'b111 runs 8 beats in sequential order, wrapping inside its aligned block of 8.
- R7: Length codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with the ordering bit at 1, give a one-column burst and set the error output. The error output keeps this value until the next start and is 0 after a start with a legal setting.
- R8: A terminate at an enabled edge with no start makes the valid output 0 from the next cycle. A start at the same edge as a terminate takes priority and begins the new burst.
- R9: While clock enable is 0, the column, valid, last-beat and error outputs hold, and start and terminate strobes are ignored.
- R10: A start at an enabled edge during a running burst abandons that burst. The next cycle shows the new start column as beat 0.
- R11: After reset, valid, last-beat and error are 0 and the column output is 0. The column output is 0 whenever valid is 0. The last-beat flag is 1 only on the final beat of a fixed-length burst.
- R12: When the read and write start strobes are both 1, the burst is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Advance enable; 0 freezes the generator |
| start_rd | input | 1 | Begin a read burst |
| start_wr | input | 1 | Begin a write burst |
| start_col | input | COL_W | Starting column, captured with the start |
| len_code | input | 3 | Burst length code |
| order_ilv | input | 1 | 0 sequential, 1 interleaved |
| wr_single | input | 1 | 1 forces one-column writes |
| term | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final one |
| mode_err | output | 1 | Captured setting was reserved |

## Verification
Every legal length code is run in both orderings from each of the first sixteen start columns and from a few high columns. This separates sequential wrap from interleaved XOR and shows whether the upper column bits leak into the block. Full-page reads started near 255 show the wrap to 0. Writes are run with the override on and off, and reserved codes are applied, so that each write and error path is covered. Gated cycles with strobes asserted, mid-burst restarts, and a start coinciding with a terminate show which event wins in each case.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

   // captured burst setting, decoded once at start
   typedef struct packed {
      logic [1:0] len_log;   // log2 of fixed burst length
      logic       full;      // row-wide wrapping burst
      logic       ilv;       // interleaved low-bit order
      logic       err;       // reserved setting was seen
   } burst_cfg_t;

   localparam logic [2:0] LEN_CODE_FULL = 3'b111;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
   import colgen_pkg::*;
#(
   parameter int WR_CAP_LOG = 3
) (
   input  logic [2:0]  len_code,
   input  logic        order_ilv,
   input  logic        wr_single,
   input  logic        is_write,
   output burst_cfg_t  cfg
);

   logic reserved;

   always_comb begin
      reserved = len_code[2] && !((len_code == LEN_CODE_FULL) && !order_ilv);
      cfg      = '0;
      if (reserved) begin
         cfg.err = 1'b1;
      end else if (is_write && wr_single) begin
         cfg.len_log = 2'd0;
      end else if (len_code == LEN_CODE_FULL) begin
         if (is_write) cfg.len_log = 2'(WR_CAP_LOG);
         else          cfg.full    = 1'b1;
      end else begin
         cfg.len_log = len_code[1:0];
         cfg.ilv     = order_ilv && (len_code != 3'b000);
      end
   end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
   import colgen_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  burst_cfg_t       cfg_in,
   input  logic             term,
   output logic             valid_q,
   output logic [COL_W-1:0] beat_q,
   output logic [COL_W-1:0] base_q,
   output burst_cfg_t       cfg_q,
   output logic             last
);

   logic [COL_W-1:0] beat_lim;

   always_comb begin
      beat_lim = COL_W'((4'd1 << cfg_q.len_log) - 4'd1);
      last     = valid_q && !cfg_q.full && (beat_q == beat_lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         beat_q  <= '0;
         base_q  <= '0;
         cfg_q   <= '0;
      end else if (clk_en) begin
         if (start) begin
            valid_q <= 1'b1;
            beat_q  <= '0;
            base_q  <= start_col;
            cfg_q   <= cfg_in;
         end else if (term) begin
            valid_q <= 1'b0;
         end else if (valid_q) begin
            if (last) valid_q <= 1'b0;
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assert_gated_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(valid_q) && $stable(beat_q) && $stable(base_q) && $stable(cfg_q)));

   assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && term && !start) |=> !valid_q);

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && start) |=> (valid_q && (beat_q == '0) && (base_q == $past(start_col))));

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
   import colgen_pkg::*;
#(
   parameter int COL_W   = 8,
   parameter int FIX_LOG = 3
) (
   input  logic             valid,
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  burst_cfg_t       cfg,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] col_raw;

   assign sum = base + beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < FIX_LOG) begin : g_low
         logic in_blk;
         assign in_blk     = cfg.len_log > 2'(i);
         assign col_raw[i] = cfg.full ? sum[i] :
                             !in_blk  ? base[i] :
                             cfg.ilv  ? (base[i] ^ beat[i]) : sum[i];
      end else begin : g_high
         assign col_raw[i] = cfg.full ? sum[i] : base[i];
      end
   end

   assign col = valid ? col_raw : '0;

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import colgen_pkg::*;
#(
   parameter int COL_W      = 8,
   parameter int WR_CAP_LOG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             start_rd,
   input  logic             start_wr,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             order_ilv,
   input  logic             wr_single,
   input  logic             term,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             last_beat,
   output logic             mode_err
);

   localparam int FIX_LOG = 3;

   if (COL_W < FIX_LOG + 1) begin : g_bad_colw
      $error("COL_W must exceed the largest fixed burst block");
   end
   if (WR_CAP_LOG < 0 || WR_CAP_LOG > FIX_LOG) begin : g_bad_cap
      $error("WR_CAP_LOG must lie within the fixed burst range");
   end

   logic             start;
   logic             is_write;
   burst_cfg_t       cfg_in;
   burst_cfg_t       cfg_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] base_q;
   logic             valid_q;
   logic             last;

   assign start    = start_rd || start_wr;
   assign is_write = start_wr && !start_rd;   // read wins when both strobe

   colgen_mode_dec #(.WR_CAP_LOG(WR_CAP_LOG)) i_dec (
      .len_code  (len_code),
      .order_ilv (order_ilv),
      .wr_single (wr_single),
      .is_write  (is_write),
      .cfg       (cfg_in)
   );

   colgen_beat_ctr #(.COL_W(COL_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .start     (start),
      .start_col (start_col),
      .cfg_in    (cfg_in),
      .term      (term),
      .valid_q   (valid_q),
      .beat_q    (beat_q),
      .base_q    (base_q),
      .cfg_q     (cfg_q),
      .last      (last)
   );

   colgen_addr_map #(.COL_W(COL_W), .FIX_LOG(FIX_LOG)) i_map (
      .valid (valid_q),
      .base  (base_q),
      .beat  (beat_q),
      .cfg   (cfg_q),
      .col   (col_out)
   );

   assign col_valid = valid_q;
   assign last_beat = last;
   assign mode_err  = cfg_q.err;

   assert_last_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid);

   assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && mode_err) |-> last_beat);

   assert_full_no_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && cfg_q.full) |-> !last_beat);

   assert_block_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !cfg_q.full) |-> (col_out[COL_W-1:FIX_LOG] == base_q[COL_W-1:FIX_LOG]));

endmodule

// File: tb/test_burst_colgen.sv
module test_burst_colgen;

   localparam int CLK_PERIOD = 10;
   localparam int COL_W      = 8;
   localparam int WATCHDOG   = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             t_cen = 1'b1;
   logic             t_rd = 1'b0;
   logic             t_wr = 1'b0;
   logic [COL_W-1:0] t_col = '0;
   logic [2:0]       t_code = '0;
   logic             t_ilv = 1'b0;
   logic             t_wsingle = 1'b0;
   logic             t_term = 1'b0;
   logic [COL_W-1:0] col_out;
   logic             col_valid;
   logic             last_beat;
   logic             mode_err;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_colgen #(.COL_W(COL_W)) i_burst_colgen (
      .clk(clk), .rst_n(rst_n), .clk_en(t_cen),
      .start_rd(t_rd), .start_wr(t_wr), .start_col(t_col),
      .len_code(t_code), .order_ilv(t_ilv), .wr_single(t_wsingle),
      .term(t_term),
      .col_out(col_out), .col_valid(col_valid),
      .last_beat(last_beat), .mode_err(mode_err)
   );

   // behavioural reference: queue of pending columns, or a running full-page pointer
   int q[$];
   bit m_valid = 1'b0;
   bit m_full  = 1'b0;
   bit m_err   = 1'b0;
   int m_col   = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 1'b0; m_full = 1'b0; m_err = 1'b0; q.delete();
      end else if (t_cen) begin
         if (t_rd || t_wr) begin
            bit is_w;
            int len;
            int st;
            is_w = t_wr && !t_rd;                         // R12
            st   = int'(t_col);
            m_full = 1'b0; m_err = 1'b0; len = 1;
            if (t_code >= 4 && !(t_code == 7 && !t_ilv)) begin
               m_err = 1'b1; len = 1;                     // R7
            end else if (is_w && t_wsingle) begin
               len = 1;                                   // R5
            end else if (t_code == 7) begin
               if (is_w) len = 8;                         // R6
               else m_full = 1'b1;                        // R3
            end else begin
               len = 1 << t_code;
            end
            q.delete();
            m_col = st;
            if (!m_full) begin
               for (int i = 0; i < len; i++) begin
                  if (t_ilv && len > 1 && t_code < 4)
                     q.push_back((st ^ i) & 255);
                  else
                     q.push_back(((st & ~(len-1)) | ((st + i) & (len-1))) & 255);
               end
            end
            m_valid = 1'b1;
         end else if (t_term) begin
            m_valid = 1'b0;
         end else if (m_valid) begin
            if (m_full) m_col = (m_col + 1) % 256;
            else begin
               void'(q.pop_front());
               if (q.size() == 0) m_valid = 1'b0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int  e_col;
         bit  e_last;
         e_col  = !m_valid ? 0 : (m_full ? m_col : q[0]);
         e_last = m_valid && !m_full && (q.size() == 1);
         checks++;
         if (col_valid !== m_valid || last_beat !== e_last || mode_err !== m_err ||
             int'(col_out) != e_col) begin
            errors++;
            $display("FAIL %s: act valid=%0b col=%0d last=%0b err=%0b exp valid=%0b col=%0d last=%0b err=%0b",
                     cur_req, col_valid, col_out, last_beat, mode_err,
                     m_valid, e_col, e_last, m_err);
         end
      end
   end

   task automatic burst(input bit rd, input bit wr, input int col, input int code,
                        input bit ilv, input bit wsingle, input int idle);
      @(negedge clk);
      t_rd = rd; t_wr = wr; t_col = COL_W'(col); t_code = 3'(code);
      t_ilv = ilv; t_wsingle = wsingle;
      @(negedge clk);
      t_rd = 1'b0; t_wr = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      checks++;
      if (col_valid !== 1'b0 || last_beat !== 1'b0 || mode_err !== 1'b0 || col_out !== '0) begin
         errors++;
         $display("FAIL R11: act valid=%0b last=%0b err=%0b col=%0d exp all 0",
                  col_valid, last_beat, mode_err, col_out);
      end

      // R1 R2 R4: every legal fixed length, both orders, many starts
      for (int code = 0; code < 4; code++)
         for (int ilv = 0; ilv < 2; ilv++) begin
            cur_req = (code == 0) ? "R4" : (ilv ? "R2" : "R1");
            for (int s = 0; s < 16; s++) burst(1, 0, s, code, ilv[0], 0, 9);
            burst(1, 0, 8'hF5, code, ilv[0], 0, 9);
            burst(1, 0, 8'hAB, code, ilv[0], 0, 9);
         end

      // R3 full-page read across the 255 to 0 wrap, then terminate (R8)
      cur_req = "R3";
      burst(1, 0, 250, 7, 0, 0, 12);
      cur_req = "R8";
      t_term = 1'b1; @(negedge clk); t_term = 1'b0;
      repeat (3) @(negedge clk);

      // R5 single-location writes, reads keep length
      cur_req = "R5";
      burst(0, 1, 8'h13, 3, 0, 1, 4);
      burst(0, 1, 8'h13, 7, 0, 1, 4);
      burst(1, 0, 8'h13, 3, 1, 1, 10);

      // R6 full-page setting on a write caps to 8 sequential beats
      cur_req = "R6";
      burst(0, 1, 8'h2D, 7, 0, 0, 10);
      burst(0, 1, 8'h02, 2, 1, 0, 6);

      // R7 reserved codes
      cur_req = "R7";
      burst(1, 0, 8'h44, 4, 0, 0, 3);
      burst(1, 0, 8'h45, 5, 1, 0, 3);
      burst(0, 1, 8'h46, 6, 0, 0, 3);
      burst(1, 0, 8'h47, 7, 1, 0, 3);
      burst(1, 0, 8'h48, 1, 0, 0, 3);   // legal start clears the flag

      // R9 gating with strobes ignored
      cur_req = "R9";
      burst(1, 0, 8'h61, 3, 0, 0, 2);
      t_cen = 1'b0; t_rd = 1'b1; t_col = 8'h10; @(negedge clk);
      t_rd = 1'b0; t_term = 1'b1; @(negedge clk);
      t_term = 1'b0; @(negedge clk);
      t_cen = 1'b1;
      repeat (8) @(negedge clk);

      // R10 restart during a burst
      cur_req = "R10";
      burst(1, 0, 8'h30, 3, 1, 0, 2);
      burst(0, 1, 8'h55, 2, 0, 0, 6);

      // R8 start and terminate on the same edge, then terminate mid burst
      cur_req = "R8";
      burst(1, 0, 8'h70, 3, 0, 0, 1);
      t_term = 1'b1; t_rd = 1'b1; t_col = 8'h81; @(negedge clk);
      t_rd = 1'b0; @(negedge clk);
      t_term = 1'b0;
      repeat (8) @(negedge clk);

      // R12 both strobes: read rules apply
      cur_req = "R12";
      burst(1, 1, 8'h9A, 2, 0, 1, 6);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: act running exp finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule